// File: doc/BRIEF.md
# Instruction Line Buffer with Sequential Prefetch and Branch Cache

This block sits between a processor's 32-bit instruction fetch port and a flash array that returns a full 128-bit line per read. The flash read time is set by a 4-bit wait-state input. Each flash access lasts that many cycles plus one. To hide this delay, the block looks for a requested word in three places before it starts a flash read. The first is the line being consumed now. The second is a one-line buffer filled by a sequential prefetch. The third is a fully associative cache of lines that were fetched after a miss.

The processor holds `req_valid` and `req_addr` until `ready` rises. `ready` and `word_out` are combinational from the buffers and the request, so a hit completes in the cycle it is presented. A miss starts one flash read, which the block holds stable until the line lands. The prefetch engine and the demand path share that single flash port. A demand for an unrelated line abandons a prefetch in flight. A demand for the line already being prefetched waits for it.

The cache has a parameterised depth (64 lines by default) and replaces the least recently used entry. LRU order is kept as one age value per line, and the ages form a permutation. Software-style controls arrive as plain inputs: prefetch enable, cache enable, a flush strobe and the latency value.

Top module: `fetch_accel`

## Requirements
- R1: In a cycle with `ready` high, `word_out` equals bits [32k+31:32k] of the 128-bit line at address `req_addr[31:4]`, where k = `req_addr[3:2]`; `flash_addr` carries the line address with bits [3:0] zero.
- R2: A request that hits no buffer and no flash read in flight starts a flash read on the next edge; `flash_rd` stays high with `flash_addr` at the line base for `latency`+1 cycles, and `ready` rises `latency`+2 cycles after the request is first presented.
- R3: A request to the line most recently delivered is ready in the same cycle it is presented.
- R4: With prefetch enabled, once a line is delivered and the flash port is idle, the next sequential line (line address + 1) is read into the prefetch buffer; a later request for it is ready with zero wait, and a request made while it is still in flight waits for that read instead of restarting. With prefetch disabled, no flash read starts without a demand miss.
- R5: A demand miss to any line other than the one being prefetched aborts the prefetch at once, so its latency equals that of a miss on an idle port.
- R6: With the cache enabled, every line delivered by a demand miss is stored, and a later request for it is ready with zero wait; with the cache disabled, the cache is neither searched nor filled.
- R7: The cache fills invalid entries first; once all entries are valid, a new line replaces the entry least recently filled or hit.
- R8: A flush strobe while the cache is disabled invalidates every cache entry; a flush strobe while the cache is enabled has no effect.
- R9: During and right after reset, `flash_rd` and `ready` are low and every buffer and cache entry is invalid.
- R10: `ready` is never high without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request, held until ready |
| req_addr | input | 32 | Byte address of the requested word |
| pf_en | input | 1 | Sequential prefetch enable |
| cache_en | input | 1 | Branch cache enable |
| flush_req | input | 1 | Invalidate cache (honoured only while cache disabled) |
| latency | input | 4 | Flash wait states; a read lasts latency+1 cycles |
| flash_rdata | input | 128 | Line returned by the flash array for flash_addr |
| ready | output | 1 | Requested word is valid this cycle |
| word_out | output | 32 | Instruction word |
| flash_rd | output | 1 | Flash read in progress |
| flash_addr | output | 32 | Line-aligned flash read address |

## Verification
Two events can land on the same edge: a sequential prefetch still using the flash port, and a demand miss to an unrelated line. The bench forces this collision. It requests a far-away line in the first cycle after a delivery, while the prefetch of the next line has only just begun at 15 wait states. It then checks that the demand arrives in exactly latency+2 cycles and that the data are the far line's. It also issues the opposite case, a request for the line being prefetched, and expects latency+1 cycles, which shows the read was reused and not restarted. Random traffic over a small window of lines, with enables and latency changed between fetches, checks every returned word and bounds every wait.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int LINE_W = 128;
    localparam int LAT_W  = 4;
    localparam int OFS_W  = $clog2(LINE_W / 8);
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int TAG_W  = ADDR_W - OFS_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic pf;
        tag_t tag;
    } rd_job_t;

    function automatic tag_t line_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic word_t pick_word(line_t l, addr_t a);
        logic [WSEL_W-1:0] k;
        k = a[OFS_W-1:OFS_W-WSEL_W];
        return l[int'(k)*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/fa_flash_seq.sv
module fa_flash_seq
    import fa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rd_job_t          start_job,
    input  logic [LAT_W-1:0] latency,
    output logic             busy,
    output logic             done,
    output rd_job_t          job
);
    logic [LAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            job  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= latency;
            job  <= start_job;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);
endmodule

// File: rtl/fa_line_cache.sv
module fa_line_cache
    import fa_pkg::*;
#(
    parameter int LINES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  tag_t                          lk_tag,
    input  logic                          touch,
    input  logic                          fill,
    input  tag_t                          fill_tag,
    input  line_t                         fill_data,
    input  logic                          flush,
    output logic                          hit,
    output line_t                         hit_data,
    output logic [LINES-1:0]              vld_o,
    output logic [LINES-1:0][$clog2(LINES)-1:0] age_o
);
    localparam int IDX_W = $clog2(LINES);
    typedef logic [IDX_W-1:0] idx_t;

    logic [LINES-1:0]  vld;
    tag_t              tags [LINES];
    line_t             data [LINES];
    idx_t              age  [LINES];

    idx_t hidx, fidx, free_idx, old_idx, victim, ref_idx, ref_age;
    logic fmatch, any_free, upd;

    always_comb begin
        hit = 1'b0; hidx = '0;
        fmatch = 1'b0; fidx = '0;
        any_free = 1'b0; free_idx = '0;
        old_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (vld[i] && tags[i] == lk_tag)   begin hit = 1'b1;    hidx = idx_t'(i); end
            if (vld[i] && tags[i] == fill_tag) begin fmatch = 1'b1; fidx = idx_t'(i); end
            if (!vld[i])                       begin any_free = 1'b1; free_idx = idx_t'(i); end
            if (age[i] == idx_t'(LINES - 1))   old_idx = idx_t'(i);
        end
        victim  = fmatch ? fidx : (any_free ? free_idx : old_idx);
        ref_idx = fill ? victim : hidx;
        ref_age = age[ref_idx];
        upd     = fill || (touch && hit);
    end

    assign hit_data = data[hidx];
    assign vld_o    = vld;

    for (genvar g = 0; g < LINES; g++) begin : g_age
        assign age_o[g] = age[g];
        always_ff @(posedge clk) begin
            if (rst) begin
                age[g] <= idx_t'(g);
            end else if (upd) begin
                if (idx_t'(g) == ref_idx) age[g] <= '0;
                else if (age[g] < ref_age) age[g] <= age[g] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (flush) vld <= '0;
            if (fill)  vld[victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill) begin
            tags[victim] <= fill_tag;
            data[victim] <= fill_data;
        end
    end
endmodule

// File: rtl/fetch_accel.sv
module fetch_accel
    import fa_pkg::*;
#(
    parameter int LINES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              pf_en,
    input  logic              cache_en,
    input  logic              flush_req,
    input  logic [3:0]        latency,
    input  logic [127:0]      flash_rdata,
    output logic              ready,
    output logic [31:0]       word_out,
    output logic              flash_rd,
    output logic [31:0]       flash_addr
);
    localparam int AGE_W = $clog2(LINES);

    tag_t    req_tag, pf_tgt;
    logic    cur_vld, pf_vld;
    tag_t    cur_tag, pf_tag;
    line_t   cur_data, pf_data, c_data, sel_line;
    logic    cur_hit, pf_hit, c_hit, use_cache, hit, waiting;
    logic    dem_start, pf_start, land, fill, touch;
    logic    eng_busy, eng_done;
    rd_job_t eng_job, start_job;
    logic [LINES-1:0]            c_vld;
    logic [LINES-1:0][AGE_W-1:0] c_age;

    assign req_tag   = line_of(req_addr);
    assign pf_tgt    = cur_tag + 1'b1;
    assign cur_hit   = cur_vld && cur_tag == req_tag;
    assign pf_hit    = pf_vld && pf_tag == req_tag;
    assign use_cache = cache_en && c_hit;
    assign hit       = cur_hit || pf_hit || use_cache;
    assign ready     = req_valid && hit;
    assign sel_line  = cur_hit ? cur_data : (pf_hit ? pf_data : c_data);
    assign word_out  = pick_word(sel_line, req_addr);

    assign waiting   = eng_busy && eng_job.tag == req_tag;
    assign dem_start = req_valid && !hit && !waiting;
    assign pf_start  = pf_en && !eng_busy && cur_vld && !dem_start
                       && !(pf_vld && pf_tag == pf_tgt);
    assign start_job = dem_start ? '{pf: 1'b0, tag: req_tag} : '{pf: 1'b1, tag: pf_tgt};
    assign land      = eng_done && !dem_start;
    assign fill      = land && !eng_job.pf && cache_en;
    assign touch     = ready && use_cache && !cur_hit && !pf_hit;

    assign flash_rd   = eng_busy;
    assign flash_addr = {eng_job.tag, {OFS_W{1'b0}}};

    fa_flash_seq u_seq (
        .clk(clk), .rst(rst),
        .start(dem_start || pf_start), .start_job(start_job),
        .latency(latency),
        .busy(eng_busy), .done(eng_done), .job(eng_job)
    );

    fa_line_cache #(.LINES(LINES)) u_cache (
        .clk(clk), .rst(rst),
        .lk_tag(req_tag), .touch(touch),
        .fill(fill), .fill_tag(eng_job.tag), .fill_data(flash_rdata),
        .flush(flush_req && !cache_en),
        .hit(c_hit), .hit_data(c_data),
        .vld_o(c_vld), .age_o(c_age)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_vld <= 1'b0;
            pf_vld  <= 1'b0;
        end else begin
            if (ready && !cur_hit && pf_hit) pf_vld <= 1'b0;
            if (land && eng_job.pf) begin
                pf_vld  <= 1'b1;
                pf_tag  <= eng_job.tag;
                pf_data <= flash_rdata;
            end
            if (land && !eng_job.pf) begin
                cur_vld  <= 1'b1;
                cur_tag  <= eng_job.tag;
                cur_data <= flash_rdata;
            end
            if (ready && !cur_hit) begin
                cur_vld  <= 1'b1;
                cur_tag  <= req_tag;
                cur_data <= sel_line;
            end
        end
    end
endmodule

// File: rtl/fa_checker.sv
module fa_checker
    import fa_pkg::*;
#(
    parameter int LINES = 64
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  req_valid,
    input logic                                  ready,
    input logic                                  pf_en,
    input logic                                  cache_en,
    input logic                                  flash_rd,
    input logic                                  eng_done,
    input logic                                  dem_start,
    input rd_job_t                               eng_job,
    input logic                                  cur_vld,
    input tag_t                                  cur_tag,
    input logic [LINES-1:0]                      c_vld,
    input logic [LINES-1:0][$clog2(LINES)-1:0]   c_age
);
    localparam int AGE_W = $clog2(LINES);
    logic [LINES-1:0] oldest;

    for (genvar g = 0; g < LINES; g++) begin : g_old
        assign oldest[g] = (c_age[g] == AGE_W'(LINES - 1));
    end

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ready |-> req_valid);  // R10

    AST_DEMAND_LANDS: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_job.pf && !dem_start && !ready)
        |=> (cur_vld && cur_tag == $past(eng_job.tag)));  // R2

    AST_NO_SPONTANEOUS_READ: assert property (@(posedge clk) disable iff (rst)
        (!pf_en && !flash_rd && !(req_valid && !ready)) |=> !flash_rd);  // R4

    AST_FLUSH_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        cache_en |=> ($countones(c_vld) >= $past($countones(c_vld))));  // R8

    AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1);  // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!flash_rd && !cur_vld && c_vld == '0));  // R9
endmodule

bind fetch_accel fa_checker #(.LINES(LINES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
    .pf_en(pf_en), .cache_en(cache_en), .flash_rd(flash_rd),
    .eng_done(eng_done), .dem_start(dem_start), .eng_job(eng_job),
    .cur_vld(cur_vld), .cur_tag(cur_tag), .c_vld(c_vld), .c_age(c_age)
);

// File: tb/fetch_accel_test.sv
module fetch_accel_test;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic         pf_en, cache_en, flush_req;
    logic [3:0]   latency;
    logic [127:0] flash_rdata;
    logic         ready;
    logic [31:0]  word_out;
    logic         flash_rd;
    logic [31:0]  flash_addr;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    fetch_accel uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .pf_en(pf_en), .cache_en(cache_en), .flush_req(flush_req),
        .latency(latency), .flash_rdata(flash_rdata),
        .ready(ready), .word_out(word_out),
        .flash_rd(flash_rd), .flash_addr(flash_addr)
    );

    // flash array model: each 32-bit word holds its own word address, scrambled
    always_comb begin
        for (int k = 0; k < 4; k++)
            flash_rdata[32*k +: 32] = {2'b00, flash_addr[31:4], 2'(k)} ^ 32'hC0DE_0000;
    end

    function automatic logic [31:0] exp_word(logic [31:0] a);
        return {2'b00, a[31:2]} ^ 32'hC0DE_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    logic        seen_rd;
    logic [31:0] seen_addr;

    // present a request, wait for ready, count wait cycles, check the word (R1)
    task automatic fetch(input logic [31:0] a, output int n);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        n = 0;
        seen_rd = 1'b0;
        seen_addr = '0;
        while (!ready && n < 100) begin
            @(negedge clk);
            #1;
            n++;
            if (n == 1) begin seen_rd = flash_rd; seen_addr = flash_addr; end
        end
        check(ready === 1'b1 && word_out === exp_word(a), "R1", "word", word_out, exp_word(a));
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic pulse_flush(input bit en_during);
        @(negedge clk);
        req_valid = 1'b0;
        cache_en  = en_during;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        int n;
        int miss_bad;
        logic [31:0] a;
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        pf_en = 1'b0; cache_en = 1'b0; flush_req = 1'b0; latency = 4'd0;
        repeat (3) @(negedge clk);
        check(ready === 1'b0 && flash_rd === 1'b0, "R9", "in reset", {ready, flash_rd}, 0);
        rst = 1'b0;
        #1;
        check(ready === 1'b0 && flash_rd === 1'b0, "R9", "after reset", {ready, flash_rd}, 0);

        // R2: cold miss timing and flash address
        latency = 4'd3;
        fetch(32'h0000_0108, n);
        check(n == 5, "R2", "miss wait lat3", n, 5);
        check(seen_rd === 1'b1 && seen_addr === 32'h0000_0100, "R2", "flash addr", seen_addr, 32'h100);
        // R3: same line, other word
        fetch(32'h0000_010C, n);
        check(n == 0, "R3", "current line hit", n, 0);
        latency = 4'd15;
        fetch(32'h0000_2004, n);
        check(n == 17, "R2", "miss wait lat15", n, 17);
        latency = 4'd0;
        fetch(32'h0000_3000, n);
        check(n == 2, "R2", "miss wait lat0", n, 2);

        // R4: prefetch on / off
        pf_en = 1'b1; latency = 4'd3;
        fetch(32'h0000_5000, n);
        check(n == 5, "R4", "first line", n, 5);
        idle(6);
        fetch(32'h0000_5014, n);
        check(n == 0, "R4", "prefetched line", n, 0);
        pf_en = 1'b0;
        idle(8);
        fetch(32'h0000_6000, n);
        idle(6);
        fetch(32'h0000_6010, n);
        check(n == 5, "R4", "no prefetch when off", n, 5);

        // R5: non-sequential demand aborts in-flight prefetch; R4 waits on matching one
        pf_en = 1'b1; latency = 4'd15;
        fetch(32'h0000_7000, n);
        fetch(32'h0000_9048, n);
        check(n == 17, "R5", "abort prefetch", n, 17);
        fetch(32'h0000_9050, n);
        check(n == 16, "R4", "join prefetch in flight", n, 16);

        // R6: cache fill and hit; disabled cache neither searched nor filled
        pf_en = 1'b0; latency = 4'd2; cache_en = 1'b1;
        idle(20);
        fetch(32'h0000_A000, n);
        fetch(32'h0000_B000, n);
        fetch(32'h0000_A004, n);
        check(n == 0, "R6", "cache hit", n, 0);
        cache_en = 1'b0;
        fetch(32'h0000_C000, n);
        fetch(32'h0000_D000, n);
        fetch(32'h0000_C008, n);
        check(n == 4, "R6", "no fill when off", n, 4);
        fetch(32'h0000_A000, n);
        check(n == 4, "R6", "no lookup when off", n, 4);

        // R8: flush ignored when enabled, honoured when disabled
        cache_en = 1'b1;
        fetch(32'h0000_B000, n);
        check(n == 0, "R6", "hit after re-enable", n, 0);
        pulse_flush(1'b1);
        fetch(32'h0000_A00C, n);
        check(n == 0, "R8", "flush ignored while on", n, 0);
        pulse_flush(1'b0);
        cache_en = 1'b1;
        fetch(32'h0000_B000, n);
        check(n == 4, "R8", "flush clears while off", n, 4);

        // R7: LRU replacement over 64 lines
        latency = 4'd0;
        pulse_flush(1'b0);
        cache_en = 1'b1;
        miss_bad = 0;
        for (int i = 0; i < 64; i++) begin
            fetch(32'h0010_0000 + i * 32'h100, n);
            if (n != 2) miss_bad++;
        end
        check(miss_bad == 0, "R7", "fills into free entries", miss_bad, 0);
        fetch(32'h0010_0000, n);
        check(n == 0, "R7", "line0 retained", n, 0);
        fetch(32'h0010_0000 + 64 * 32'h100, n);
        check(n == 2, "R7", "65th line misses", n, 2);
        fetch(32'h0010_0004, n);
        check(n == 0, "R7", "recently hit line kept", n, 0);
        fetch(32'h0010_0100, n);
        check(n == 2, "R7", "LRU line evicted", n, 2);
        fetch(32'h0010_0300, n);
        check(n == 0, "R7", "younger line kept", n, 0);
        fetch(32'h0010_0200, n);
        check(n == 2, "R7", "next LRU evicted", n, 2);

        // random traffic: data always correct, wait bounded (R1, R2, R5)
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            req_valid = 1'b0;
            pf_en    = 1'($urandom % 2);
            cache_en = 1'($urandom % 2);
            latency  = 4'($urandom % 5);
            if ($urandom % 20 == 0) pulse_flush(1'b0);
            a = 32'h0000_4000 + ($urandom % 12) * 16 + ($urandom % 4) * 4;
            fetch(a, n);
            check(n <= 6, "R2", "random wait bound", n, 6);
        end

        finish_up();
    end
endmodule